// File: doc/BRIEF.md
# Routed Level Interrupt Aggregator

This block collects nine level-sensitive interrupt sources and presents them on three request lines toward an upstream interrupt controller. Each source passes through a two-flop synchroniser, then through a per-source polarity stage selected by one shared configuration word. The resulting "active" level is latched into a pending field that each of the three lines keeps for all nine sources. Software routes a source to a line by setting that source's enable bit in the line's register. A request line is raised while any of its sources is both enabled and pending.

Software services a line by reading its register to find the causes, and then writing ones into the pending field to acknowledge them. Because every source is level-sensitive, a source that is still active when it is acknowledged is latched again at once. A single write to a line register can change its enables and acknowledge causes together. The usual start-up write disables everything on a line and clears its causes in one access.

Top module: `irq_agg_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), the polarity word, every enable bit, every pending bit and every request output are 0, and the synchroniser flops hold 1 (the idle level of an active-low source).
- R2: Word offset 0x0 holds the polarity field in bits 8:0. Bit k = 1 makes source k active high, and bit k = 0 makes it active low. Bits 31:9 read 0. A write takes effect on the pending capture at the next rising edge.
- R3: Line n (n = 0..2) has its register at byte offset 0x4 + 4n, with enables in bits 8:0 and pending in bits 24:16. All other bits read 0. Offsets 0x10 to 0x1C, and any address with bits 1:0 non-zero, read 0, and writes to them change nothing.
- R4: A change on a source input reaches the pending bits at the third rising edge after the input changes. Two edges are spent in the synchroniser.
- R5: A source's pending bit is set in every line's register while the source is active, whether or not it is enabled on that line.
- R6: Writing 1 to bit 16+k of a line register clears pending bit k of that line, unless source k is still active, in which case the bit stays 1. Writing 0 there leaves the bit as it is.
- R7: irq_out[n] is 1 at the rising edge after the AND of line n's enables and pending bits becomes non-zero. It returns to 0 at the edge after that AND becomes zero.
- R8: One write to a line register loads bits 8:0 into its enables and applies bits 24:16 as clears in the same edge, so writing 0x01FF0000 leaves a line with no enables and no pending bits from inactive sources.
- R9: A write to one line register leaves the enables and pending bits of the other lines unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the word |
| bus_wdata | input | 32 | Write data word |
| bus_rdata | output | 32 | Read data of the addressed word, combinational |
| src_in | input | 9 | Asynchronous interrupt source levels |
| irq_out | output | 3 | Request lines, active high |

## Verification
Register writes show on bus_rdata from the rising edge that samples the strobe. A source edge shows in the pending bits three edges later, and the request line rises one edge after that. A polarity write moves the pending bits one edge after the write. The bench drives inputs and samples outputs only on the falling edge, and a behavioural model keeps the synchroniser delay as a two-entry queue. Every falling edge compares the request lines and the addressed read word against that model. Directed checks probe the exact edge on which each of these delays ends, and the edge just before it.

// File: rtl/irq_agg_pkg.sv
// Package: shared constants and types for the routed interrupt aggregator.
// Assumes a 32-bit data word and that the pending field starts at bit 16.
package irq_agg_pkg;
    localparam int DATA_W   = 32;
    localparam int PEND_LSB = 16;

    // Kind of register selected by a bus address.
    typedef enum logic [1:0] {
        REG_POL  = 2'd0,
        REG_LINE = 2'd1,
        REG_NONE = 2'd2
    } reg_kind_e;
endpackage

// File: rtl/irq_agg_sync.sv
// Module: two-flop synchroniser followed by per-source polarity correction.
// Assumes: pol_i comes from a register in the same clock domain. The flops
// reset to RST_VAL so that idle active-low sources do not look active.
module irq_agg_sync #(
    parameter int NUM_SRC = 9,
    parameter logic [NUM_SRC-1:0] RST_VAL = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] pol_i,
    output logic [NUM_SRC-1:0] act_o
);
    logic [NUM_SRC-1:0] meta_q;
    logic [NUM_SRC-1:0] sync_q;

    // Two-stage capture of the asynchronous source levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= src_i;
            sync_q <= meta_q;
        end
    end

    // Polarity: a 1 in pol_i means high is active, a 0 means low is active.
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_pol
        always_comb act_o[k] = pol_i[k] ? sync_q[k] : ~sync_q[k];
    end

    // R4
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n)) |=> (sync_q == $past(src_i, 2)));
endmodule

// File: rtl/irq_agg_line.sv
// Module: one request line, holding enable and pending fields for every source.
// Assumes: act_i is synchronous and wr_i is a single-cycle write strobe.
// Pending bits follow a level: an active source sets its bit every cycle.
module irq_agg_line #(
    parameter int NUM_SRC = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [NUM_SRC-1:0] wen_i,
    input  logic [NUM_SRC-1:0] wclr_i,
    input  logic [NUM_SRC-1:0] act_i,
    output logic [NUM_SRC-1:0] en_o,
    output logic [NUM_SRC-1:0] pend_o,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] clr_mask;
    logic               req_any;

    // Clear mask applies only on a write strobe to this line.
    always_comb clr_mask = wr_i ? wclr_i : '0;

    // A line requests service when an enabled source is pending.
    always_comb req_any = |(en_q & pend_q);

    // Enable field storage, loaded whole on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)    en_q <= '0;
        else if (wr_i) en_q <= wen_i;
    end

    // Pending capture: write-one clear first, then the active level sets again.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_mask) | act_i;
    end

    // Registered request output.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= req_any;
    end

    assign en_o   = en_q;
    assign pend_o = pend_q;

    // R5
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((~pend_q & $past(act_i)) == '0));

    // R6
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_i) |=> ((pend_q & $past(wclr_i) & ~$past(act_i)) == '0));

    // R8
    en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_i) |=> (en_q == $past(wen_i)));

    // R7
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && (|(en_q & pend_q))) |=> irq_o);

    // R7
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !(|(en_q & pend_q))) |=> !irq_o);
endmodule

// File: rtl/irq_agg_regs.sv
// Module: register decode, polarity storage and read multiplexer.
// Assumes word-aligned accesses. Any address with bits 1:0 non-zero selects
// nothing. Read data is combinational from the address.
module irq_agg_regs
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC   = 9,
    parameter int NUM_LINES = 3,
    parameter int ADDR_W    = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_sel,
    input  logic                              bus_wr,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [DATA_W-1:0]                 bus_wdata,
    output logic [DATA_W-1:0]                 bus_rdata,
    input  logic [NUM_LINES-1:0][NUM_SRC-1:0] en_i,
    input  logic [NUM_LINES-1:0][NUM_SRC-1:0] pend_i,
    output logic [NUM_SRC-1:0]                pol_o,
    output logic [NUM_LINES-1:0]              line_wr_o,
    output logic [NUM_SRC-1:0]                wen_o,
    output logic [NUM_SRC-1:0]                wclr_o
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]     word_idx;
    logic                 aligned;
    logic                 wr_stb;
    reg_kind_e            kind;
    logic [NUM_LINES-1:0] line_hit;
    logic [NUM_SRC-1:0]   pol_q;

    always_comb word_idx = bus_addr[ADDR_W-1:2];
    always_comb aligned  = (bus_addr[1:0] == 2'b00);
    always_comb wr_stb   = bus_sel && bus_wr;

    // One-hot line selection from the word index (line n sits at word n+1).
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_hit
        always_comb line_hit[n] = aligned && (word_idx == IDX_W'(n + 1));
    end

    // Classify the access.
    always_comb begin
        if (aligned && word_idx == '0) kind = REG_POL;
        else if (|line_hit)            kind = REG_LINE;
        else                           kind = REG_NONE;
    end

    // Polarity word storage.
    always_ff @(posedge clk) begin
        if (!rst_n)                           pol_q <= '0;
        else if (wr_stb && kind == REG_POL)   pol_q <= bus_wdata[NUM_SRC-1:0];
    end

    // Write strobes and field slices for the line registers.
    always_comb line_wr_o = wr_stb ? line_hit : '0;
    always_comb wen_o     = bus_wdata[NUM_SRC-1:0];
    always_comb wclr_o    = bus_wdata[PEND_LSB +: NUM_SRC];

    // Read multiplexer; unused bits and unmapped words return zero.
    always_comb begin
        bus_rdata = '0;
        case (kind)
            REG_POL: bus_rdata[NUM_SRC-1:0] = pol_q;
            REG_LINE: begin
                for (int n = 0; n < NUM_LINES; n++) begin
                    if (line_hit[n]) begin
                        bus_rdata[NUM_SRC-1:0]          = en_i[n];
                        bus_rdata[PEND_LSB +: NUM_SRC] = pend_i[n];
                    end
                end
            end
            default: bus_rdata = '0;
        endcase
    end

    assign pol_o = pol_q;

    // R2
    pol_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_stb && aligned && word_idx == '0) |=> (pol_o == $past(bus_wdata[NUM_SRC-1:0])));

    // R3
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!aligned || word_idx > IDX_W'(NUM_LINES)) |-> (bus_rdata == '0));

    // R3
    line_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(line_wr_o));
endmodule

// File: rtl/irq_agg_top.sv
// Module: routed level interrupt aggregator top.
// Assumes one clock domain for the bus; the source inputs may be asynchronous.
// NUM_SRC must not exceed 16 so that the enable and pending fields fit the word.
module irq_agg_top #(
    parameter int NUM_SRC   = 9,
    parameter int NUM_LINES = 3,
    parameter int ADDR_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_SRC-1:0]   src_in,
    output logic [NUM_LINES-1:0] irq_out
);
    logic [NUM_SRC-1:0]                pol;
    logic [NUM_SRC-1:0]                act;
    logic [NUM_LINES-1:0]              line_wr;
    logic [NUM_SRC-1:0]                wen;
    logic [NUM_SRC-1:0]                wclr;
    logic [NUM_LINES-1:0][NUM_SRC-1:0] en_all;
    logic [NUM_LINES-1:0][NUM_SRC-1:0] pend_all;

    irq_agg_regs #(
        .NUM_SRC(NUM_SRC), .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .en_i(en_all), .pend_i(pend_all),
        .pol_o(pol), .line_wr_o(line_wr), .wen_o(wen), .wclr_o(wclr)
    );

    irq_agg_sync #(
        .NUM_SRC(NUM_SRC), .RST_VAL({NUM_SRC{1'b1}})
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .src_i(src_in), .pol_i(pol), .act_o(act)
    );

    // One line instance per request output.
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        irq_agg_line #(.NUM_SRC(NUM_SRC)) u_line (
            .clk(clk), .rst_n(rst_n),
            .wr_i(line_wr[n]), .wen_i(wen), .wclr_i(wclr), .act_i(act),
            .en_o(en_all[n]), .pend_o(pend_all[n]), .irq_o(irq_out[n])
        );
    end

    // R1
    reset_out_chk: assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0));
endmodule

// File: tb/irq_agg_top_tb.sv
module irq_agg_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [8:0]  src_in = 9'h1FF;
    logic [2:0]  irq_out;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit started = 0;

    // Behavioural reference state.
    logic [8:0] m_pol;
    logic [8:0] m_en [3];
    logic [8:0] m_pend [3];
    logic [2:0] m_irq;
    logic [8:0] m_dly [$];

    irq_agg_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_in(src_in), .irq_out(irq_out)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] model_read(logic [4:0] a);
        logic [31:0] r;
        int idx;
        r = '0;
        idx = int'(a[4:2]);
        if (a[1:0] == 2'b00) begin
            if (idx == 0) r[8:0] = m_pol;
            else if (idx <= 3) r = {7'b0, m_pend[idx-1], 7'b0, m_en[idx-1]};
        end
        return r;
    endfunction

    // Reference model, advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pol = '0;
            m_irq = '0;
            for (int n = 0; n < 3; n++) begin
                m_en[n] = '0;
                m_pend[n] = '0;
            end
            m_dly.delete();
            m_dly.push_back(9'h1FF);
            m_dly.push_back(9'h1FF);
        end else begin
            logic [8:0] active;
            int idx;
            active = ~(m_dly[0] ^ m_pol);
            idx = int'(bus_addr[4:2]);
            for (int n = 0; n < 3; n++) begin
                m_irq[n] = |(m_en[n] & m_pend[n]);
                if (bus_sel && bus_wr && bus_addr[1:0] == 2'b00 && idx == n + 1) begin
                    m_pend[n] = (m_pend[n] & ~bus_wdata[24:16]) | active;
                    m_en[n] = bus_wdata[8:0];
                end else begin
                    m_pend[n] = m_pend[n] | active;
                end
            end
            if (bus_sel && bus_wr && bus_addr == 5'h00) m_pol = bus_wdata[8:0];
            void'(m_dly.pop_front());
            m_dly.push_back(src_in);
        end
        started = 1;
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Continuous comparison against the model on every falling edge.
    always @(negedge clk) begin
        if (started) begin
            chk("R7 irq_out vs model", {29'b0, irq_out}, {29'b0, m_irq});
            chk("R3 read word vs model", bus_rdata, model_read(bus_addr));
        end
    end

    // Watchdog: an expired run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        bus_sel = 1'b1;
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        #1;
        bus_sel = 1'b0;
        bus_wr = 1'b0;
    endtask

    task automatic peek(string tag, logic [4:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        wait_n(4);
        // R1: reset values.
        peek("R1 polarity after reset", 5'h00, 32'h0);
        peek("R1 line0 after reset", 5'h04, 32'h0);
        peek("R1 line1 after reset", 5'h08, 32'h0);
        peek("R1 line2 after reset", 5'h0C, 32'h0);
        chk("R1 irq after reset", {29'b0, irq_out}, 32'h0);
        rst_n = 1'b1;
        wait_n(1);

        // R8: start-up clear writes, then routing.
        wr(5'h04, 32'h01FF0000);
        wr(5'h08, 32'h01FF0000);
        wr(5'h0C, 32'h01FF0000);
        wr(5'h04, 32'h00000003);
        wr(5'h08, 32'h00000004);
        peek("R3 line0 enables", 5'h04, 32'h00000003);

        // R4 / R5 / R7: source 0 goes active (low).
        src_in[0] = 1'b0;
        wait_n(2);
        peek("R4 pending not yet after two edges", 5'h04, 32'h00000003);
        wait_n(1);
        peek("R4 pending on third edge", 5'h04, 32'h00010003);
        peek("R5 pending on line without enable", 5'h08, 32'h00010004);
        peek("R5 pending on line2", 5'h0C, 32'h00010000);
        chk("R7 irq0 still low", {29'b0, irq_out}, 32'h0);
        wait_n(1);
        chk("R7 irq0 raised", {29'b0, irq_out}, 32'h1);

        // R6: acknowledge after the source goes idle.
        src_in[0] = 1'b1;
        wait_n(3);
        wr(5'h04, 32'h00010003);
        peek("R6 pending cleared", 5'h04, 32'h00000003);
        peek("R9 line1 untouched", 5'h08, 32'h00010004);
        chk("R7 irq0 still high one edge", {29'b0, irq_out}, 32'h1);
        wait_n(1);
        chk("R7 irq0 dropped", {29'b0, irq_out}, 32'h0);

        // R6: acknowledge while source 2 stays active.
        src_in[2] = 1'b0;
        wait_n(4);
        wr(5'h04, 32'h00040007);
        peek("R6 active source re-latched", 5'h04, 32'h00040007);
        wait_n(1);
        chk("R7 irq0 and irq1 from source 2", {29'b0, irq_out}, 32'h3);

        // R2: polarity flip makes an idle-high source active.
        src_in[2] = 1'b1;
        wait_n(3);
        wr(5'h00, 32'h00000020);
        peek("R2 polarity readback", 5'h00, 32'h00000020);
        wait_n(1);
        peek("R2 pending from new polarity", 5'h0C, 32'h00250000);

        // R8: combined disable-and-clear on line 0.
        wr(5'h00, 32'h00000000);
        wait_n(2);
        wr(5'h04, 32'h01FF0000);
        peek("R8 line0 fully cleared", 5'h04, 32'h00000000);
        peek("R9 line2 untouched", 5'h0C, 32'h00250000);
        wait_n(1);
        chk("R8 irq0 low after clear", {29'b0, irq_out[0]}, 32'h0);

        // R3: unmapped and misaligned accesses.
        wr(5'h14, 32'hFFFFFFFF);
        peek("R3 unmapped reads zero", 5'h14, 32'h0);
        wr(5'h05, 32'h000001FF);
        peek("R3 misaligned write ignored", 5'h04, 32'h00000000);
        peek("R3 misaligned read zero", 5'h09, 32'h0);
        wr(5'h00, 32'hFFFFFFFF);
        peek("R2 reserved polarity bits read zero", 5'h00, 32'h000001FF);
        wr(5'h00, 32'h00000000);

        // Mixed traffic checked against the model every cycle.
        for (int i = 0; i < 600; i++) begin
            src_in = 9'($urandom);
            if ($urandom_range(3, 0) == 0) begin
                logic [4:0] a;
                a = 5'($urandom_range(5, 0) * 4);
                wr(a, $urandom);
            end else begin
                bus_addr = 5'($urandom_range(7, 0) * 4);
                wait_n(1);
            end
        end

        wait_n(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule